// File: doc/BRIEF.md
# Banked Register Port for an Audio Receiver

This block sits between a microcontroller and the receiver core of a serial audio input. The microcontroller sees a 32-location byte space through an asynchronous strobe interface: an active-low select, a read/write line, a 5-bit address, and split data lines. The data lines are an input byte, an output byte and a drive enable that turns the output on. Two banked locations hold either the sticky status registers or their interrupt-enable masks. Two locations hold control registers. The remaining 28 locations form a byte buffer that the receiver core also writes and reads through its own port. The core raises status events with per-bit set inputs. An active-low interrupt output reports any enabled event.

The select line is synchronized into the system clock. A state machine then carries out each access with the states IDLE, LATCH, WRITE, HOLD, READ and CLEAR, and these transitions:
- IDLE goes to LATCH when the synchronized select is seen low.
- LATCH captures the address, the read/write line, the input byte, the bank bit and the addressed value. It then goes to READ for a read or to WRITE for a write.
- WRITE commits the stored byte and goes to HOLD.
- HOLD returns to IDLE when the select is seen high.
- READ drives the captured value until the select is seen high, then goes to CLEAR.
- CLEAR removes the status bits that were returned and goes back to IDLE.

Top module: `mrp_reg_port`

## Requirements
- R1: After reset, all status, enable, control and buffer bytes are zero, irq_n is high, bus_drive is low and buf_mode is 0.
- R2: The address map is as follows. Address 2 is control register 1 and address 3 is control register 0 (also presented on ctrl0_out). Addresses 4 to 31 are buffer bytes 0 to 27, in that order.
- R3: Addresses 0 and 1 reach status register 0 and 1 when bit 0 of control register 1 is 0. They reach enable register 0 and 1 when that bit is 1. A write to address 0 or 1 while the status pair is visible has no effect.
- R4: bus_drive is high only during a read access, starting the fourth clock edge after cs_n falls and ending when the synchronized select returns high. While it is high, bus_dout holds the addressed value captured at the start of the access.
- R5: The address, rw and bus_din are captured once per access, at the fourth clock edge after cs_n falls. Later changes during the same access have no effect.
- R6: A 1 on core_set0 or core_set1 sets the matching status bit, which stays set until it is cleared by a read.
- R7: A read of a visible status register clears exactly the bits it returned, once the access ends. A set input active in the clearing cycle keeps its bit set.
- R8: irq_n is low exactly when some status bit and the same bit of its enable register are both 1.
- R9: Bits 2:1 of control register 1 select the buffer mode shown on buf_mode. The encoding 3 reads back as written but gives buf_mode 0.
- R10: Each select assertion performs exactly one write, or one read-clear, however long it lasts.
- R11: core_we with core_idx below 28 writes buffer byte core_idx. A larger index changes nothing. core_rd_data returns byte core_rd_idx, or 0 for an index of 28 or more.
- R12: When the microcontroller write and a core write hit the same buffer byte in the same cycle, the microcontroller value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Microcontroller address |
| bus_din | input | 8 | Write data from the microcontroller |
| bus_dout | output | 8 | Read data to the microcontroller |
| bus_drive | output | 1 | Output enable for bus_dout |
| irq_n | output | 1 | Active-low interrupt |
| core_we | input | 1 | Core buffer write enable |
| core_idx | input | 5 | Core buffer write index |
| core_wdata | input | 8 | Core buffer write data |
| core_set0 | input | 8 | Per-bit set for status register 0 |
| core_set1 | input | 8 | Per-bit set for status register 1 |
| core_rd_idx | input | 5 | Core buffer read index |
| core_rd_data | output | 8 | Core buffer read data |
| buf_mode | output | 2 | Effective buffer mode |
| ctrl0_out | output | 8 | Control register 0 contents |

## Verification
Two pairs of functions can land on the same clock edge. A microcontroller buffer write can coincide with a core write to the same byte. A status read-clear can coincide with a core set of the same bit. The bench times a core write to the exact edge of the WRITE state. It also holds a set input active through a whole status read, which covers the CLEAR edge. A behavioural reference model, updated on every edge, judges both cases. Directed reads then confirm that the microcontroller byte survived and that the re-set bit is still reported.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_WRITE,
        ST_HOLD,
        ST_READ,
        ST_CLEAR
    } acc_state_e;

    localparam int BANK_REGS = 2;
    localparam int CTRL_REGS = 2;
    localparam int BUF_BASE  = BANK_REGS + CTRL_REGS;
    localparam int BANK_BIT  = 0;
    localparam int MODE_LSB  = 1;
endpackage

// File: rtl/mrp_cs_sync.sv
module mrp_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_low
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], cs_n};
        end
    end

    assign cs_low = ~sync_q[STAGES-1];
endmodule

// File: rtl/mrp_access_fsm.sv
module mrp_access_fsm
    import mrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low,
    input  logic rw,
    output logic cap_stb,
    output logic wr_stb,
    output logic clr_stb,
    output logic drive
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_low) state_d = ST_LATCH;
            ST_LATCH: state_d = rw ? ST_READ : ST_WRITE;
            ST_WRITE: state_d = ST_HOLD;
            ST_HOLD:  if (!cs_low) state_d = ST_IDLE;
            ST_READ:  if (!cs_low) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_stb = 1'b0;
        wr_stb  = 1'b0;
        clr_stb = 1'b0;
        drive   = 1'b0;
        unique case (state_q)
            ST_LATCH: cap_stb = 1'b1;
            ST_WRITE: wr_stb  = 1'b1;
            ST_READ:  drive   = 1'b1;
            ST_CLEAR: clr_stb = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/mrp_buffer.sv
module mrp_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 28,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [IDX_W-1:0]  a_rd_idx,
    output logic [DATA_W-1:0] a_rd_data,
    input  logic              b_we,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [IDX_W-1:0]  b_rd_idx,
    output logic [DATA_W-1:0] b_rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (a_we && a_idx == IDX_W'(i)) begin
                mem[i] <= a_wdata;
            end else if (b_we && b_idx == IDX_W'(i)) begin
                mem[i] <= b_wdata;
            end
        end
    end

    always_comb begin
        a_rd_data = '0;
        b_rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (a_rd_idx == IDX_W'(k)) a_rd_data = mem[k];
            if (b_rd_idx == IDX_W'(k)) b_rd_data = mem[k];
        end
    end
endmodule

// File: rtl/mrp_reg_port.sv
module mrp_reg_port
    import mrp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int BUF_DEPTH   = 28,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive,
    output logic              irq_n,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_idx,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] core_set0,
    input  logic [DATA_W-1:0] core_set1,
    input  logic [ADDR_W-1:0] core_rd_idx,
    output logic [DATA_W-1:0] core_rd_data,
    output logic [1:0]        buf_mode,
    output logic [DATA_W-1:0] ctrl0_out
);
    localparam int IDX_W = ADDR_W;
    localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(BANK_REGS);
    localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(BANK_REGS + 1);
    localparam logic [ADDR_W-1:0] A_BUF   = ADDR_W'(BUF_BASE);

    logic cs_low, cap_stb, wr_stb, clr_stb;

    logic [BANK_REGS-1:0][DATA_W-1:0] st_q, ie_q, clr_mask, set_vec;
    logic [DATA_W-1:0] ctrl1_q, ctrl0_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q, bank_q;
    logic [DATA_W-1:0] din_q, snap_q, rd_mux, buf_rd_mcu;
    logic              q_is_bank, q_is_buf, in_is_bank;
    logic              mcu_buf_we;
    logic [IDX_W-1:0]  mcu_wr_idx, mcu_rd_idx;

    mrp_cs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .cs_low (cs_low)
    );

    mrp_access_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_low  (cs_low),
        .rw      (rw),
        .cap_stb (cap_stb),
        .wr_stb  (wr_stb),
        .clr_stb (clr_stb),
        .drive   (bus_drive)
    );

    assign in_is_bank = (addr < A_CTRL1);
    assign q_is_bank  = (addr_q < A_CTRL1);
    assign q_is_buf   = (addr_q >= A_BUF);
    assign mcu_rd_idx = IDX_W'(addr - A_BUF);
    assign mcu_wr_idx = IDX_W'(addr_q - A_BUF);
    assign mcu_buf_we = wr_stb && q_is_buf;

    mrp_buffer #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_we      (mcu_buf_we),
        .a_idx     (mcu_wr_idx),
        .a_wdata   (din_q),
        .a_rd_idx  (mcu_rd_idx),
        .a_rd_data (buf_rd_mcu),
        .b_we      (core_we),
        .b_idx     (core_idx),
        .b_wdata   (core_wdata),
        .b_rd_idx  (core_rd_idx),
        .b_rd_data (core_rd_data)
    );

    // Read selection from the live address, used only when the access is captured.
    always_comb begin
        if (in_is_bank) begin
            rd_mux = ctrl1_q[BANK_BIT] ? ie_q[addr[0]] : st_q[addr[0]];
        end else if (addr == A_CTRL1) begin
            rd_mux = ctrl1_q;
        end else if (addr == A_CTRL0) begin
            rd_mux = ctrl0_q;
        end else begin
            rd_mux = buf_rd_mcu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b0;
            bank_q <= 1'b0;
            din_q  <= '0;
            snap_q <= '0;
        end else if (cap_stb) begin
            addr_q <= addr;
            rw_q   <= rw;
            bank_q <= ctrl1_q[BANK_BIT];
            din_q  <= bus_din;
            snap_q <= rd_mux;
        end
    end

    assign set_vec[0] = core_set0;
    assign set_vec[1] = core_set1;

    for (genvar k = 0; k < BANK_REGS; k++) begin : g_bank
        assign clr_mask[k] = (clr_stb && q_is_bank && !bank_q && addr_q[0] == k[0])
                             ? snap_q : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[k] <= '0;
                ie_q[k] <= '0;
            end else begin
                st_q[k] <= (st_q[k] & ~clr_mask[k]) | set_vec[k];
                if (wr_stb && q_is_bank && bank_q && addr_q[0] == k[0]) begin
                    ie_q[k] <= din_q;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl1_q <= '0;
            ctrl0_q <= '0;
        end else if (wr_stb) begin
            if (addr_q == A_CTRL1) ctrl1_q <= din_q;
            if (addr_q == A_CTRL0) ctrl0_q <= din_q;
        end
    end

    assign buf_mode  = (ctrl1_q[MODE_LSB +: 2] == 2'b11) ? 2'b00 : ctrl1_q[MODE_LSB +: 2];
    assign ctrl0_out = ctrl0_q;
    assign bus_dout  = snap_q;
    assign irq_n     = ~|(st_q & ie_q);
endmodule

// File: rtl/mrp_reg_port_chk.sv
module mrp_reg_port_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_stb,
    input logic                clr_stb,
    input logic                bus_drive,
    input logic                rw_q,
    input logic [1:0]          buf_mode,
    input logic [2*DATA_W-1:0] status,
    input logic [2*DATA_W-1:0] ie
);
    assert_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> rw_q);

    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_clear_ends_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !bus_drive);

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> ((status & $past(status)) == $past(status)));

    assert_enable_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(ie));

    assert_mode_never_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode != 2'b11);
endmodule

bind mrp_reg_port mrp_reg_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .clr_stb   (clr_stb),
    .bus_drive (bus_drive),
    .rw_q      (rw_q),
    .buf_mode  (buf_mode),
    .status    (st_q),
    .ie        (ie_q)
);

// File: tb/mrp_reg_port_tb_top.sv
`timescale 1ns/1ps
module mrp_reg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_drive, irq_n;
    logic       core_we = 1'b0;
    logic [4:0] core_idx = '0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_set0 = '0;
    logic [7:0] core_set1 = '0;
    logic [4:0] core_rd_idx = '0;
    logic [7:0] core_rd_data;
    logic [1:0] buf_mode;
    logic [7:0] ctrl0_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mrp_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_drive(bus_drive),
        .irq_n(irq_n), .core_we(core_we), .core_idx(core_idx),
        .core_wdata(core_wdata), .core_set0(core_set0), .core_set1(core_set1),
        .core_rd_idx(core_rd_idx), .core_rd_data(core_rd_data),
        .buf_mode(buf_mode), .ctrl0_out(ctrl0_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st[2], m_ie[2], m_c1, m_c0;
    int m_buf[28];
    int m_s1, m_s2, m_ph, m_aq, m_dq, m_bq, m_snap;
    int clr0, clr1;
    bit low, do_wr;

    function automatic int m_read(input int a);
        if (a < 2) return (m_c1 & 1) ? m_ie[a] : m_st[a];
        if (a == 2) return m_c1;
        if (a == 3) return m_c0;
        return m_buf[a-4];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = '{0, 0}; m_ie = '{0, 0}; m_c1 = 0; m_c0 = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
            m_s1 = 1; m_s2 = 1; m_ph = 0; m_aq = 0; m_dq = 0; m_bq = 0; m_snap = 0;
        end else begin
            low = (m_s2 == 0);
            m_s2 = m_s1;
            m_s1 = int'(cs_n);
            clr0 = 0; clr1 = 0; do_wr = 0;
            case (m_ph)
                0: if (low) m_ph = 1;
                1: begin
                    m_aq = int'(addr); m_dq = int'(bus_din); m_bq = m_c1 & 1;
                    m_snap = m_read(int'(addr));
                    m_ph = rw ? 4 : 2;
                end
                2: begin do_wr = 1; m_ph = 3; end
                3: if (!low) m_ph = 0;
                4: if (!low) m_ph = 5;
                default: begin
                    if (m_aq < 2 && m_bq == 0) begin
                        if (m_aq == 0) clr0 = m_snap; else clr1 = m_snap;
                    end
                    m_ph = 0;
                end
            endcase
            m_st[0] = (m_st[0] & ~clr0 & 255) | int'(core_set0);
            m_st[1] = (m_st[1] & ~clr1 & 255) | int'(core_set1);
            if (core_we && core_idx < 28) m_buf[core_idx] = int'(core_wdata);
            if (do_wr) begin
                if (m_aq < 2) begin
                    if (m_bq == 1) m_ie[m_aq] = m_dq;
                end else if (m_aq == 2) m_c1 = m_dq;
                else if (m_aq == 3) m_c0 = m_dq;
                else m_buf[m_aq-4] = m_dq;
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int em;
            cycles++;
            chk(bus_drive == (m_ph == 4), "R4 bus_drive", int'(bus_drive), int'(m_ph == 4));
            if (m_ph == 4) chk(int'(bus_dout) == m_snap, "R2 read data", int'(bus_dout), m_snap);
            em = ((m_st[0] & m_ie[0]) | (m_st[1] & m_ie[1])) != 0 ? 0 : 1;
            chk(int'(irq_n) == em, "R8 irq_n", int'(irq_n), em);
            em = (m_c1 >> 1) & 3;
            if (em == 3) em = 0;
            chk(int'(buf_mode) == em, "R9 buf_mode", int'(buf_mode), em);
            em = core_rd_idx < 28 ? m_buf[core_rd_idx] : 0;
            chk(int'(core_rd_data) == em, "R11 core_rd_data", int'(core_rd_data), em);
            chk(int'(ctrl0_out) == m_c0, "R2 ctrl0_out", int'(ctrl0_out), m_c0);
        end
    end

    // ---------------- access tasks ----------------
    task automatic mcu_write(input int a, input int d, input int hold = 6);
        @(negedge clk);
        addr = 5'(a); rw = 1'b0; bus_din = 8'(d); cs_n = 1'b0;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic mcu_read(input int a, output int v);
        @(negedge clk);
        addr = 5'(a); rw = 1'b1; cs_n = 1'b0;
        v = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (bus_drive) begin v = int'(bus_dout); break; end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic read_expect(input int a, input int exp, input string tag);
        int v;
        mcu_read(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(irq_n == 1'b1, "R1 irq_n after reset", int'(irq_n), 1);
        chk(bus_drive == 1'b0, "R1 bus_drive after reset", int'(bus_drive), 0);
        chk(buf_mode == 2'd0, "R1 buf_mode after reset", int'(buf_mode), 0);
        core_rd_idx = 5'd27;
        @(negedge clk);
        chk(core_rd_data == 8'h00, "R1 buffer after reset", int'(core_rd_data), 0);
        read_expect(3, 0, "R1 ctrl0 after reset");
        read_expect(0, 0, "R1 status0 after reset");

        // R2: map
        mcu_write(3, 'hA5);
        read_expect(3, 'hA5, "R2 ctrl0 readback");
        mcu_write(4, 'h11);
        mcu_write(31, 'h22);
        core_rd_idx = 5'd0;
        @(negedge clk);
        chk(core_rd_data == 8'h11, "R2 addr4 is byte0", int'(core_rd_data), 'h11);
        core_rd_idx = 5'd27;
        @(negedge clk);
        chk(core_rd_data == 8'h22, "R2 addr31 is byte27", int'(core_rd_data), 'h22);
        read_expect(31, 'h22, "R2 buffer readback");

        // R6 / R7: sticky status and read-clear
        core_set0 = 8'h81;
        @(negedge clk);
        core_set0 = 8'h00;
        repeat (3) @(negedge clk);
        read_expect(0, 'h81, "R6 sticky status0");
        read_expect(0, 'h00, "R7 status0 cleared by read");

        // R3 / R8: banking and interrupt
        mcu_write(2, 'h01);
        mcu_write(0, 'h01);
        read_expect(0, 'h01, "R3 enable0 visible");
        mcu_write(2, 'h00);
        core_set0 = 8'h01;
        @(negedge clk);
        core_set0 = 8'h00;
        @(negedge clk);
        chk(irq_n == 1'b0, "R8 enabled event asserts irq_n", int'(irq_n), 0);
        core_set1 = 8'h02;
        @(negedge clk);
        core_set1 = 8'h00;
        mcu_write(1, 'hFF);
        mcu_write(2, 'h01);
        read_expect(1, 'h00, "R3 write to status bank ignored");
        mcu_write(2, 'h00);
        read_expect(0, 'h01, "R7 status0 read");
        @(negedge clk);
        chk(irq_n == 1'b1, "R8 irq_n released after clear", int'(irq_n), 1);
        read_expect(1, 'h02, "R6 status1 kept across traffic");

        // R7: set active during the clearing cycle keeps the bit
        core_set1 = 8'h02;
        read_expect(1, 'h02, "R7 status1 with set held");
        core_set1 = 8'h00;
        read_expect(1, 'h02, "R7 set wins over clear");
        read_expect(1, 'h00, "R7 status1 cleared");

        // R9: modes
        mcu_write(2, 'h06);
        chk(buf_mode == 2'd0, "R9 reserved gives mode 0", int'(buf_mode), 0);
        read_expect(2, 'h06, "R9 reserved stored");
        mcu_write(2, 'h04);
        chk(buf_mode == 2'd2, "R9 mode 2", int'(buf_mode), 2);

        // R5 / R10: long access with changing inputs
        @(negedge clk);
        addr = 5'd3; rw = 1'b0; bus_din = 8'h3C; cs_n = 1'b0;
        repeat (6) @(negedge clk);
        addr = 5'd2; bus_din = 8'hFF;
        repeat (40) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        read_expect(3, 'h3C, "R10 one write per long access");
        read_expect(2, 'h04, "R5 late address change ignored");

        // R12: same-byte collision on the WRITE edge
        core_rd_idx = 5'd6;
        @(negedge clk);
        addr = 5'd10; rw = 1'b0; bus_din = 8'h5A; cs_n = 1'b0;
        repeat (4) @(negedge clk);
        core_we = 1'b1; core_idx = 5'd6; core_wdata = 8'hEE;
        @(negedge clk);
        core_we = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(core_rd_data == 8'h5A, "R12 microcontroller wins", int'(core_rd_data), 'h5A);

        // R11: core port
        core_we = 1'b1; core_idx = 5'd28; core_wdata = 8'h77;
        @(negedge clk);
        core_idx = 5'd7; core_wdata = 8'h33;
        @(negedge clk);
        core_we = 1'b0;
        core_rd_idx = 5'd28;
        @(negedge clk);
        chk(core_rd_data == 8'h00, "R11 index 28 reads zero", int'(core_rd_data), 0);
        read_expect(11, 'h33, "R11 core write seen by microcontroller");
        read_expect(10, 'h5A, "R11 out-of-range write changed nothing");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule